// File: doc/BRIEF.md
# Four-Queue Read Port Selector

This block steers the read side of four internal queues onto one shared 40-bit output bus. In multiplexed operation a 2-bit select picks one queue. The chosen queue's word drives the whole bus, and its data-available status drives a single composite flag. In lane operation every queue owns a fixed 10-bit slice of the bus and every queue can be read at once. The composite flag is then parked at its "no data" level.

The select is captured on the read clock. Word and flag pipelines then present the newly chosen queue after a latency that depends on the timing mode: one stage in standard mode, two in first-word-fall-through mode. The read strobes back to the queues are gated so that a queue is popped only when it is addressed and reports data. Mode and timing configuration are static and change only while reset is asserted.

Top module: `qrs_read_steer`

## Requirements
- R1: While reset is applied and after it, until the first update, `rd_data` is 0, `q_rd` is 0 when `rd_en` is 0, and `comp_flag` is at its no-data level (0 in standard mode, 1 in fall-through mode).
- R2: In multiplexed mode (`cfg_mux`=1), a select captured on clock edge k addresses queue `os_sel`. On edge k+1 that queue's 40-bit word (bits [40*i+39:40*i] of `q_data` for queue i) enters the word pipeline. The word is visible on `rd_data` right after edge k+1 in standard mode (`cfg_fwft`=0), and right after the next enabled edge in fall-through mode (`cfg_fwft`=1).
- R3: In lane mode (`cfg_mux`=0), the pipeline input is {q3[9:0], q2[9:0], q1[9:0], q0[9:0]}, where qi[9:0] is the low 10 bits of queue i's word. It has the same latency as R2.
- R4: The word pipeline advances only on edges where `rd_cs_n` is 0, whatever the value of `rd_en`. With `rd_cs_n`=1, `rd_data` holds.
- R5: In standard multiplexed mode, `comp_flag` after edge k+1 equals `q_avail` of the queue captured at edge k, as sampled at edge k+1 (1 = data available).
- R6: In fall-through multiplexed mode, `comp_flag` after edge k+2 equals the inverse of the availability sampled at edge k+1 (0 = output ready).
- R7: In lane mode, `comp_flag` stays at the no-data level: 0 in standard mode, 1 in fall-through mode.
- R8: In multiplexed mode, `q_rd[i]` is 1 only when all of these hold: i equals the captured select, `rd_en`=1, `rd_cs_n`=0 and `q_avail[i]`=1. At most one strobe is high.
- R9: In lane mode, `q_rd[i]` = `rd_en` & ~`rd_cs_n` & `q_avail[i]` for every queue.
- R10: `q_flag` equals `q_avail` in standard mode and its inverse in fall-through mode, in both bus modes, without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mux | input | 1 | 1 = multiplexed bus, 0 = fixed lanes |
| cfg_fwft | input | 1 | 1 = fall-through timing, 0 = standard timing |
| os_sel | input | 2 | Queue select, captured each clock |
| rd_cs_n | input | 1 | Read chip select, active low |
| rd_en | input | 1 | Read request, active high |
| q_avail | input | 4 | Per-queue data-available status |
| q_data | input | 160 | Per-queue 40-bit words, queue i at bits [40*i+39:40*i] |
| q_rd | output | 4 | Per-queue read strobes |
| q_flag | output | 4 | Per-queue status in the mode's polarity |
| rd_data | output | 40 | Shared output bus |
| comp_flag | output | 1 | Composite status of the selected queue |

## Verification
The bench changes the select on consecutive edges in both timing modes. A flag or word pipeline one stage too short or too long would then show the previous queue's status or word one cycle early or late. It holds chip select high while the queue data keeps changing, to catch a pipeline that advances without it or that waits on the read request. It also drives availability and the read request freely in lane mode. That catches a strobe gated by the stale select, or a composite flag that leaks a queue's status. It checks the fall-through polarity on both the per-queue and the composite flags.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  parameter int unsigned QRS_NQ   = 4;
  parameter int unsigned QRS_LANE = 10;

  typedef enum logic {
    TM_STD  = 1'b0,
    TM_FWFT = 1'b1
  } tmode_e;
endpackage

// File: rtl/qrs_rst_sync.sv
module qrs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_i
);
  logic r1, r2;
  logic r1_nx, r2_nx;

  always_comb begin
    r1_nx = 1'b1;
    r2_nx = r1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 <= 1'b0;
      r2 <= 1'b0;
    end else begin
      r1 <= r1_nx;
      r2 <= r2_nx;
    end
  end

  assign rst_i = r2;
endmodule

// File: rtl/qrs_delay.sv
module qrs_delay #(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst_i,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] tap1,
  output logic [W-1:0] tap2
);
  logic [W-1:0] s1, s2, s1_nx, s2_nx;

  always_comb begin
    s1_nx = s1;
    s2_nx = s2;
    if (en) begin
      s1_nx = din;
      s2_nx = s1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= s1_nx;
      s2 <= s2_nx;
    end
  end

  assign tap1 = s1;
  assign tap2 = s2;

  // R4: stages hold on edges without enable
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_i)
    !en |=> ($stable(tap1) && $stable(tap2)));
  // R2: second stage takes the first stage's old word
  a_r2_shift: assert property (@(posedge clk) disable iff (!rst_i)
    en |=> (tap2 == $past(tap1)));
endmodule

// File: rtl/qrs_rd_gate.sv
module qrs_rd_gate #(
  parameter int unsigned NQ = 4,
  localparam int unsigned SW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic          mux_mode,
  input  logic          rd_go,
  input  logic [SW-1:0] sel_q,
  input  logic [NQ-1:0] avail,
  output logic [NQ-1:0] q_rd
);
  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic addressed;
    assign addressed = !mux_mode || (sel_q == SW'(i));
    assign q_rd[i]   = rd_go && addressed && avail[i];
  end

  // R8: one queue at most in multiplexed mode
  a_r8_single: assert property (@(posedge clk) disable iff (!rst_i)
    mux_mode |-> $onehot0(q_rd));
  // R8/R9: never pop a queue without data
  a_r9_needs_data: assert property (@(posedge clk) disable iff (!rst_i)
    (q_rd & ~avail) == '0);
endmodule

// File: rtl/qrs_read_steer.sv
module qrs_read_steer
  import qrs_pkg::*;
#(
  parameter int unsigned NQ     = QRS_NQ,
  parameter int unsigned LANE_W = QRS_LANE,
  localparam int unsigned DW = NQ * LANE_W,
  localparam int unsigned SW = $clog2(NQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mux,
  input  logic             cfg_fwft,
  input  logic [SW-1:0]    os_sel,
  input  logic             rd_cs_n,
  input  logic             rd_en,
  input  logic [NQ-1:0]    q_avail,
  input  logic [NQ*DW-1:0] q_data,
  output logic [NQ-1:0]    q_rd,
  output logic [NQ-1:0]    q_flag,
  output logic [DW-1:0]    rd_data,
  output logic             comp_flag
);
  logic          rst_i;
  tmode_e        tmode;
  logic [SW-1:0] sel_q, sel_nx;
  logic [DW-1:0] sel_word, lane_word, pipe_in;
  logic [DW-1:0] d1, d2;
  logic [0:0]    f1, f2, f_in;
  logic          fsel;

  assign tmode = cfg_fwft ? TM_FWFT : TM_STD;

  qrs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_i(rst_i));

  always_comb sel_nx = os_sel;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) sel_q <= '0;
    else        sel_q <= sel_nx;
  end

  assign sel_word = q_data[int'(sel_q)*DW +: DW];

  for (genvar i = 0; i < NQ; i++) begin : g_lane
    assign lane_word[i*LANE_W +: LANE_W] = q_data[i*DW +: LANE_W];
  end

  assign pipe_in = cfg_mux ? sel_word : lane_word;
  assign f_in    = q_avail[sel_q];

  qrs_delay #(.W(DW)) u_dpipe (
    .clk(clk), .rst_i(rst_i), .en(!rd_cs_n),
    .din(pipe_in), .tap1(d1), .tap2(d2)
  );

  qrs_delay #(.W(1)) u_fpipe (
    .clk(clk), .rst_i(rst_i), .en(1'b1),
    .din(f_in), .tap1(f1), .tap2(f2)
  );

  qrs_rd_gate #(.NQ(NQ)) u_gate (
    .clk(clk), .rst_i(rst_i), .mux_mode(cfg_mux),
    .rd_go(rd_en && !rd_cs_n), .sel_q(sel_q),
    .avail(q_avail), .q_rd(q_rd)
  );

  assign rd_data   = (tmode == TM_FWFT) ? d2 : d1;
  assign fsel      = cfg_mux && ((tmode == TM_FWFT) ? f2[0] : f1[0]);
  assign comp_flag = (tmode == TM_FWFT) ? !fsel : fsel;
  assign q_flag    = (tmode == TM_FWFT) ? ~q_avail : q_avail;

  // R7: composite parked in lane mode
  a_r7_comp_idle: assert property (@(posedge clk) disable iff (!rst_i)
    !cfg_mux |-> (comp_flag == cfg_fwft));
  // R5: standard composite follows captured queue one edge later
  a_r5_std_comp: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_mux && !cfg_fwft) |=> (comp_flag == $past(q_avail[sel_q])));
  // R4: bus holds while chip select is high
  a_r4_bus_hold: assert property (@(posedge clk) disable iff (!rst_i)
    rd_cs_n |=> $stable(rd_data));
endmodule

// File: tb/qrs_read_steer_bench.sv
module qrs_read_steer_bench;
  localparam int CLK_P = 10;
  localparam int NQ = 4;
  localparam int LW = 10;
  localparam int DW = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mux = 1'b1, cfg_fwft = 1'b0;
  logic [1:0] os_sel = '0;
  logic rd_cs_n = 1'b1, rd_en = 1'b0;
  logic [NQ-1:0] q_avail = '0;
  logic [NQ*DW-1:0] q_data = '0;
  logic [NQ-1:0] q_rd, q_flag;
  logic [DW-1:0] rd_data;
  logic comp_flag;

  int n_chk = 0, n_bad = 0, cycles = 0;

  always #(CLK_P/2) clk = ~clk;

  qrs_read_steer u_qrs_read_steer (
    .clk(clk), .rst_n(rst_n), .cfg_mux(cfg_mux), .cfg_fwft(cfg_fwft),
    .os_sel(os_sel), .rd_cs_n(rd_cs_n), .rd_en(rd_en), .q_avail(q_avail),
    .q_data(q_data), .q_rd(q_rd), .q_flag(q_flag), .rd_data(rd_data),
    .comp_flag(comp_flag)
  );

  // reference model: histories of pipeline entries
  int m_cnt = 0;
  int m_sel = 0;
  logic [DW-1:0] hd[$];
  bit hf[$];

  function automatic logic [DW-1:0] word_of(int q);
    return q_data[q*DW +: DW];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sel = 0; hd.delete(); hf.delete();
    end else if (m_cnt < 2) begin
      m_cnt++;
    end else begin
      logic [DW-1:0] w;
      if (cfg_mux) w = word_of(m_sel);
      else for (int i = 0; i < NQ; i++) w[i*LW +: LW] = q_data[i*DW +: LW];
      if (!rd_cs_n) hd.push_back(w);
      hf.push_back(q_avail[m_sel]);
      m_sel = int'(os_sel);
      if (hd.size() > 4) void'(hd.pop_front());
      if (hf.size() > 4) void'(hf.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: cycles %0d expected < 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int lat = cfg_fwft ? 2 : 1;
    logic [DW-1:0] ed = '0;
    bit ef = 1'b0, fs;
    logic [NQ-1:0] er, efl;
    if (hd.size() >= lat) ed = hd[hd.size()-lat];
    if (hf.size() >= lat) ef = hf[hf.size()-lat];
    fs = cfg_mux && ef;
    for (int i = 0; i < NQ; i++)
      er[i] = rd_en && !rd_cs_n && q_avail[i] && (!cfg_mux || m_sel == i);
    efl = cfg_fwft ? ~q_avail : q_avail;
    chk(cfg_mux ? "R2 R4 data" : "R3 R4 data", rd_data, ed);
    chk(!cfg_mux ? "R7 comp" : (cfg_fwft ? "R6 comp" : "R5 comp"),
        DW'(comp_flag), DW'(cfg_fwft ? !fs : fs));
    chk(cfg_mux ? "R8 rd" : "R9 rd", DW'(q_rd), DW'(er));
    chk("R10 flag", DW'(q_flag), DW'(efl));
  endtask

  task automatic step(logic [1:0] s, logic cs_n, logic en,
                      logic [NQ-1:0] av, logic [NQ*DW-1:0] d);
    @(negedge clk);
    os_sel = s; rd_cs_n = cs_n; rd_en = en; q_avail = av; q_data = d;
    #2 compare();
  endtask

  function automatic logic [NQ*DW-1:0] rnd_data();
    logic [NQ*DW-1:0] v;
    for (int i = 0; i < NQ * DW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_cfg(logic mux, logic fw);
    @(negedge clk);
    rst_n = 1'b0; rd_en = 1'b0; rd_cs_n = 1'b1; q_avail = '0; os_sel = '0;
    q_data = '0; cfg_mux = mux; cfg_fwft = fw;
    q_avail = 4'hF;
    #2;
    // R1: reset state
    chk("R1 reset data", rd_data, '0);
    chk("R1 reset comp", DW'(comp_flag), DW'(fw));
    chk("R1 reset rd", DW'(q_rd), '0);
    q_avail = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) step(2'd0, 1'b1, 1'b0, 4'h0, '0);
    // directed: walk select on consecutive edges, data ready only in queue 2
    for (int i = 0; i < 4; i++) step(2'(i), 1'b0, 1'b0, 4'b0100, rnd_data());
    for (int i = 0; i < 6; i++) step(2'd2, 1'b0, 1'b1, 4'b0100, rnd_data());
    // chip select high: bus must hold while data changes (R4)
    for (int i = 0; i < 6; i++) step(2'(i), 1'b1, 1'b1, 4'hF, rnd_data());
    // random traffic
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 7);
      step(2'($urandom), r == 0, 1'($urandom), 4'($urandom), rnd_data());
    end
  endtask

  initial begin
    run_cfg(1'b1, 1'b0);
    run_cfg(1'b1, 1'b1);
    run_cfg(1'b0, 1'b0);
    run_cfg(1'b0, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule